// File: doc/BRIEF.md
# Square-Root Carry-Select Adder with Increment-Derived Upper Results

This block is a purely combinational adder. It takes two operands of configurable width and a carry input, and returns a sum of the same width together with a carry output. The operand bits are cut into consecutive groups, and the groups get wider toward the most significant end.

The lowest group is a plain two-bit ripple adder driven by the external carry input. Every higher group does three things:

- It ripples its own bits with a carry of zero.
- It forms the carry-of-one alternative by adding one to that zero-carry result, including its carry bit.
- It lets the carry that actually arrives from the group below choose between the two alternatives.

Each group therefore owns one ripple chain instead of two, and the carry path through the block crosses one multiplexer per group.

The group layout is a parameter. Each group width is a 4-bit field of a packed vector, with the least significant group in the lowest field. Elaboration checks reject a layout that does not fit. Typical builds are 16, 32, 64 and 128 bits wide.

Top module: `csel_sqrt_adder`

## Requirements
- R1: For every input, the concatenation {co, sum} equals a + b + ci, taken as an unsigned value of WIDTH+1 bits.
- R2: Bits [1:0] of the sum come from a two-bit ripple adder fed directly by ci: sum[1:0] equals the low two bits of a[1:0] + b[1:0] + ci.
- R3: When the carry entering an upper group is 1, that group outputs its zero-carry result plus one. When that carry is 0, the group outputs the zero-carry result unchanged.
- R4: With b equal to the bitwise inverse of a and ci = 1, the all-ones zero-carry results wrap to zero in every group: sum is all zeros and co is 1.
- R5: With b equal to the bitwise inverse of a and ci = 0, sum is all ones and co is 0.
- R6: With b = 0 and ci = 0, sum equals a and co is 0.
- R7: When a and b both have their most significant bit set, co is 1. co is the carry leaving the most significant group.
- R8: The default 16-bit layout uses groups of 2, 2, 3, 4 and 5 bits. A different layout can be given through the GROUPS parameter, which holds one 4-bit width field per group with group 0 in the lowest field. The widths must sum to WIDTH, the first width must be 2, and every width must lie from 1 to 11. The adder is correct for a 64-bit layout of 2, 2, 3, 4, 5, 6, 7, 8, 9, 9 and 9.
- R9: A carry entering at bit 0 travels across every group boundary: for a = 2^k - 1, b = 0 and ci = 1, sum equals 2^k for each k below WIDTH.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a    | input     | WIDTH | First operand |
| b    | input     | WIDTH | Second operand |
| ci   | input     | 1     | Carry into bit 0 |
| sum  | output    | WIDTH | Sum bits |
| co   | output    | 1     | Carry out of the most significant group |

## Verification
Two things can happen in the same evaluation. The increment path of a group can wrap its all-ones zero-carry result. At that same moment, the select from below can pick that wrapped value, and the wrapped carry must then become the select of the next group.

The bench provokes this with b equal to the inverse of a, and with operands of the form 2^k - 1 plus a carry input. These make every boundary in both the 16-bit and the 64-bit layouts select the incremented value at once. A scoreboard judges each case against an arithmetic reference computed in the bench, comparing the full sum and the carry out.

// File: rtl/csel_pkg.sv
package csel_pkg;

   localparam int unsigned MAX_GRP   = 32;
   localparam int unsigned FIELD_W   = 4;
   localparam int unsigned MAX_GRP_W = 11;

   typedef logic [MAX_GRP*FIELD_W-1:0] grp_list_t;

   // width of group idx taken from its 4-bit field
   function automatic int unsigned grp_w(grp_list_t list, int unsigned idx);
      return int'(list[idx*FIELD_W +: FIELD_W]);
   endfunction

   // first bit position of group idx (sum of all widths below it)
   function automatic int unsigned grp_lo(grp_list_t list, int unsigned idx);
      int unsigned acc;
      acc = 0;
      for (int unsigned k = 0; k < idx; k++) acc += grp_w(list, k);
      return acc;
   endfunction

endpackage

// File: rtl/csel_rca.sv
module csel_rca #(
   parameter int unsigned N = 2
) (
   input  logic [N-1:0] a,
   input  logic [N-1:0] b,
   input  logic         ci,
   output logic [N-1:0] s,
   output logic         co
);
   logic [N:0] c;
   assign c[0] = ci;

   for (genvar i = 0; i < N; i++) begin : g_fa
      logic p;
      assign p      = a[i] ^ b[i];
      assign s[i]   = p ^ c[i];
      assign c[i+1] = (a[i] & b[i]) | (p & c[i]);
   end

   assign co = c[N];
endmodule

// File: rtl/csel_inc.sv
module csel_inc #(
   parameter int unsigned N = 3
) (
   input  logic [N-1:0] d,
   output logic [N-1:0] q
);
   logic [N-1:0] all_low;   // AND of all bits below position i

   assign all_low[0] = 1'b1;
   assign q[0]       = ~d[0];

   for (genvar i = 1; i < N; i++) begin : g_bit
      assign all_low[i] = all_low[i-1] & d[i-1];
      assign q[i]       = d[i] ^ all_low[i];
   end
endmodule

// File: rtl/csel_mux.sv
module csel_mux #(
   parameter int unsigned N = 3
) (
   input  logic         sel,
   input  logic [N-1:0] d0,
   input  logic [N-1:0] d1,
   output logic [N-1:0] q
);
   for (genvar i = 0; i < N; i++) begin : g_bit
      assign q[i] = (d0[i] & ~sel) | (d1[i] & sel);
   end
endmodule

// File: rtl/csel_group.sv
module csel_group #(
   parameter int unsigned W     = 2,
   parameter bit          FIRST = 1'b0
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         ci,
   output logic [W-1:0] s,
   output logic         co
);
   if (FIRST) begin : g_base
      csel_rca #(.N(W)) u_rca (
         .a (a),
         .b (b),
         .ci(ci),
         .s (s),
         .co(co)
      );
   end else begin : g_sel
      logic [W-1:0] s_zero;
      logic         c_zero;
      logic [W:0]   r_zero;
      logic [W:0]   r_one;
      logic [W:0]   r_pick;

      csel_rca #(.N(W)) u_rca (
         .a (a),
         .b (b),
         .ci(1'b0),
         .s (s_zero),
         .co(c_zero)
      );

      assign r_zero = {c_zero, s_zero};

      csel_inc #(.N(W+1)) u_inc (
         .d(r_zero),
         .q(r_one)
      );

      csel_mux #(.N(W+1)) u_mux (
         .sel(ci),
         .d0 (r_zero),
         .d1 (r_one),
         .q  (r_pick)
      );

      assign s  = r_pick[W-1:0];
      assign co = r_pick[W];
   end
endmodule

// File: rtl/csel_sqrt_adder.sv
module csel_sqrt_adder
   import csel_pkg::*;
#(
   parameter int unsigned WIDTH  = 16,
   parameter int unsigned NGRP   = 5,
   parameter grp_list_t   GROUPS = grp_list_t'(128'h54322)
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  logic             ci,
   output logic [WIDTH-1:0] sum,
   output logic             co
);
   localparam int unsigned TOTAL = grp_lo(GROUPS, NGRP);

   if (NGRP < 1 || NGRP > MAX_GRP) begin : g_bad_count
      $error("csel_sqrt_adder: group count out of range");
   end
   if (TOTAL != WIDTH) begin : g_bad_total
      $error("csel_sqrt_adder: group widths do not sum to WIDTH");
   end
   if (grp_w(GROUPS, 0) != 2) begin : g_bad_first
      $error("csel_sqrt_adder: lowest group must be two bits");
   end

   logic [NGRP:0] carry;
   assign carry[0] = ci;

   for (genvar g = 0; g < NGRP; g++) begin : g_grp
      localparam int unsigned LO = grp_lo(GROUPS, g);
      localparam int unsigned GW = grp_w(GROUPS, g);

      if (GW < 1 || GW > MAX_GRP_W) begin : g_bad_w
         $error("csel_sqrt_adder: group width out of range");
      end

      csel_group #(.W(GW), .FIRST(g == 0)) u_grp (
         .a (a[LO +: GW]),
         .b (b[LO +: GW]),
         .ci(carry[g]),
         .s (sum[LO +: GW]),
         .co(carry[g+1])
      );
   end

   assign co = carry[NGRP];
endmodule

// File: rtl/csel_sqrt_adder_chk.sv
module csel_sqrt_adder_chk #(
   parameter int unsigned WIDTH = 16
) (
   input logic [WIDTH-1:0] a,
   input logic [WIDTH-1:0] b,
   input logic             ci,
   input logic [WIDTH-1:0] sum,
   input logic             co
);
   logic [WIDTH:0] ref_total;
   logic [2:0]     ref_low;

   always_comb begin
      ref_total = {1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, ci};
      ref_low   = {1'b0, a[1:0]} + {1'b0, b[1:0]} + {2'b00, ci};

      a_r1_total_matches: assert final ({co, sum} == ref_total)
         else $error("R1 total mismatch");
      a_r2_low_group: assert final (sum[1:0] == ref_low[1:0])
         else $error("R2 low group mismatch");
      a_r4_wrap_to_zero: assert final (!(a == ~b && ci) || (sum == '0 && co))
         else $error("R4 wrap mismatch");
      a_r5_all_ones: assert final (!(a == ~b && !ci) || (sum == '1 && !co))
         else $error("R5 all-ones mismatch");
      a_r6_identity: assert final (!(b == '0 && !ci) || (sum == a && !co))
         else $error("R6 identity mismatch");
      a_r7_top_carry: assert final (!(a[WIDTH-1] && b[WIDTH-1]) || co)
         else $error("R7 carry out mismatch");
   end
endmodule

bind csel_sqrt_adder csel_sqrt_adder_chk #(.WIDTH(WIDTH)) u_chk (
   .a  (a),
   .b  (b),
   .ci (ci),
   .sum(sum),
   .co (co)
);

// File: tb/tb_csel_sqrt_adder.sv
module tb_csel_sqrt_adder;
   import csel_pkg::*;

   localparam time TCK = 4ns;

   logic clk   = 1'b0;
   logic rst_n = 1'b0;
   always #(TCK/2) clk = ~clk;

   logic [63:0] a64 = '0, b64 = '0;
   logic        ci  = 1'b0;
   logic [15:0] sum16;
   logic        co16;
   logic [63:0] sum64;
   logic        co64;

   csel_sqrt_adder dut (
      .a  (a64[15:0]),
      .b  (b64[15:0]),
      .ci (ci),
      .sum(sum16),
      .co (co16)
   );

   csel_sqrt_adder #(
      .WIDTH (64),
      .NGRP  (11),
      .GROUPS(grp_list_t'(128'h99987654322))
   ) dut_w64 (
      .a  (a64),
      .b  (b64),
      .ci (ci),
      .sum(sum64),
      .co (co64)
   );

   typedef struct {
      logic [16:0] e16;
      logic [64:0] e64;
      string       tag;
   } item_t;

   item_t q[$];
   int checks   = 0;
   int failures = 0;
   bit done     = 1'b0;

   // driver: apply one vector per cycle and queue its expectation
   task automatic drive(input logic [63:0] x, input logic [63:0] y,
                        input logic c, input string tag);
      item_t it;
      @(posedge clk);
      a64 = x; b64 = y; ci = c;
      it.e16 = {1'b0, x[15:0]} + {1'b0, y[15:0]} + {16'd0, c};
      it.e64 = {1'b0, x} + {1'b0, y} + {64'd0, c};
      it.tag = tag;
      q.push_back(it);
   endtask

   // monitor: compare half a cycle after each vector
   always @(negedge clk) begin
      if (rst_n && q.size() > 0) begin
         item_t it;
         it = q.pop_front();
         checks++;
         if ({co16, sum16} !== it.e16) begin
            failures++;
            $display("FAIL %s w16 actual=%h expected=%h", it.tag, {co16, sum16}, it.e16);
         end
         checks++;
         if ({co64, sum64} !== it.e64) begin
            failures++;
            $display("FAIL %s w64 actual=%h expected=%h", it.tag, {co64, sum64}, it.e64);
         end
      end
   end

   initial begin
      #(TCK * 200000);
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      checks++;   // zero inputs held through reset give a zero result
      if ({co16, sum16} !== 17'd0 || {co64, sum64} !== 65'd0) begin
         failures++;
         $display("FAIL R1 reset actual=%h expected=0", {co16, sum16});
      end
      rst_n = 1'b1;

      // R6 identity with zero addend
      drive(64'h0123_4567_89AB_CDEF, 64'd0, 1'b0, "R6");
      drive(64'hFFFF_0000_FFFF_0000, 64'd0, 1'b0, "R6");
      // R4 / R5 inverse operands, carry toggled
      drive(64'hA5A5_5A5A_0F0F_F0F0, ~64'hA5A5_5A5A_0F0F_F0F0, 1'b1, "R4");
      drive(64'hA5A5_5A5A_0F0F_F0F0, ~64'hA5A5_5A5A_0F0F_F0F0, 1'b0, "R5");
      drive(64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 1'b1, "R4");
      drive(64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, "R1");
      drive(64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, "R1");
      // R7 both top bits set
      drive(64'h8000_0000_0000_8000, 64'h8000_0000_0000_8000, 1'b0, "R7");
      // R2 low group with carry in toggled
      for (int v = 0; v < 32; v++)
         drive(64'(v[1:0]), 64'(v[3:2]), v[4], "R2");
      // R3 carry into group 1 set or clear with fixed upper bits
      drive(64'h0000_0000_0000_0F03, 64'h0000_0000_0000_0000, 1'b1, "R3");
      drive(64'h0000_0000_0000_0F03, 64'h0000_0000_0000_0000, 1'b0, "R3");
      drive(64'h0000_0000_0000_007E, 64'h0000_0000_0000_0002, 1'b0, "R3");
      // R9 carry from bit 0 across every boundary
      for (int k = 1; k < 64; k++)
         drive((64'd1 << k) - 64'd1, 64'd0, 1'b1, "R9");
      // R1 / R8 random vectors on both layouts
      for (int n = 0; n < 400; n++)
         drive({$urandom, $urandom}, {$urandom, $urandom}, 1'($urandom), "R8");

      @(posedge clk);
      @(posedge clk);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule